// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps the local time of a network timestamping unit. It holds a 40-bit nanosecond count with a 32-bit fraction of a nanosecond below it. On every clock of the 125 MHz timing clock it adds a fixed 8 ns step. It also adds or takes away a programmable correction, counted in units of 2^-32 ns. Software uses that correction to pull the local oscillator onto a reference frequency. The live nanosecond count goes straight to the timestamp capture logic next to the block.

Software reaches the counter through a small word-wide register port. Reading the fraction word freezes a copy of the whole time, so the following reads of the low and high nanosecond words belong to the same instant. Writing is also done in two steps. The low nanosecond word is held back until the high word arrives, and then both are loaded together. A halt bit stops the counter; it comes out of reset set, so the counter does not run until software clears it. A sticky flag records each wrap of the 40-bit count. Software clears that flag by writing a one to it.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time and fraction read as zero, the adjust register (address 3) reads zero, and the control register (address 4) reads 0x8000_0000: halt bit 31 is set and the overflow bit 0 is clear.
- R2: While control bit 31 is set, the nanosecond count and the fraction hold their values. The counter runs on every cycle in which that bit is clear.
- R3: On every running cycle the 72-bit value {ns, fraction} grows by 8·2^32 plus or minus the magnitude held in adjust bits 30:0. Adjust bit 31 set means subtract. Carries out of the fraction flow into the nanosecond count.
- R4: A read of address 0 returns the live fraction and captures the live nanosecond count. Reads of address 1 and address 2 then return that captured count, not the live one. Read data appears one cycle after the read strobe.
- R5: Address 2 returns ns[39:32] in bits 7:0 and zero in bits 31:8.
- R6: A write to address 1 only stages a value and leaves the time unchanged. A write to address 2 loads {wdata[7:0], staged low} into the count in one cycle and clears the fraction.
- R7: A carry out of bit 39 of the count sets control bit 0 and the ovf_flag output, and both stay set. Writing control with bit 0 set clears the flag. Writing control with bit 0 clear leaves it unchanged.
- R8: Writes to address 0 have no effect on the time.
- R9: Address 3 reads back the last value written to it.
- R10: The time_ns output always shows the live 40-bit nanosecond count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one 8 ns tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word select: 0 fraction, 1 ns low, 2 ns high, 3 adjust, 4 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| time_ns | output | 40 | Live nanosecond count |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
The hardest event to reach is a wrap of the 40-bit count, because counting up from zero would take about 18 minutes of simulated time. The bench gets there by loading a time a few steps below 2^40 through the staged low and high writes, then letting the counter run for an exact number of cycles. Before each randomised trial it clears the flag, so the wrap prediction is checked on every trial. The frozen copy of the time has its own directed case. That case reads the fraction while the counter is running, lets the counter run on, and confirms that the low and high reads still return the older value.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    SEL_FRAC = 3'd0,
    SEL_NSLO = 3'd1,
    SEL_NSHI = 3'd2,
    SEL_ADJ  = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;

  localparam int CTRL_HALT_BIT = 31;
  localparam int CTRL_OVF_BIT  = 0;
endpackage

// File: rtl/tc_rst_sync.sv
module tc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
  parameter int NS_W    = 40,
  parameter int FR_W    = 32,
  parameter int STEP_NS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [NS_W-1:0]  load_ns,
  input  logic             adj_neg,
  input  logic [FR_W-2:0]  adj_mag,
  output logic [NS_W-1:0]  ns_o,
  output logic [FR_W-1:0]  frac_o,
  output logic             wrap_o
);
  localparam int TW = NS_W + FR_W;

  logic [TW-1:0] cur_q, cur_d;
  logic [TW-1:0] step_base, mag_ext, step_eff;
  logic [TW:0]   sum;

  // 8 ns step in fixed point, trimmed by the signed correction
  always_comb begin
    step_base = {NS_W'(STEP_NS), {FR_W{1'b0}}};
    mag_ext   = TW'(adj_mag);
    step_eff  = adj_neg ? (step_base - mag_ext) : (step_base + mag_ext);
    sum       = {1'b0, cur_q} + {1'b0, step_eff};
  end

  // a load overrides the tick
  always_comb begin
    cur_d  = cur_q;
    wrap_o = 1'b0;
    if (load) begin
      cur_d = {load_ns, {FR_W{1'b0}}};
    end else if (run) begin
      cur_d  = sum[TW-1:0];
      wrap_o = sum[TW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (load || run) begin
      cur_q <= cur_d;
    end
  end

  assign ns_o   = cur_q[TW-1:FR_W];
  assign frac_o = cur_q[FR_W-1:0];
endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wrap,
  output logic [DW-1:0] adj_o,
  output logic [DW-1:0] low_stage_o,
  output logic          halt_o,
  output logic          ovf_o
);
  import tc_pkg::*;

  logic          wr_adj, wr_ctrl, wr_low;
  logic [DW-1:0] adj_d, low_d;
  logic          halt_d, ovf_d;

  always_comb begin
    wr_adj  = wr_en && (addr == SEL_ADJ);
    wr_ctrl = wr_en && (addr == SEL_CTRL);
    wr_low  = wr_en && (addr == SEL_NSLO);
    adj_d   = wr_adj  ? wdata : adj_o;
    low_d   = wr_low  ? wdata : low_stage_o;
    halt_d  = wr_ctrl ? wdata[CTRL_HALT_BIT] : halt_o;
    ovf_d   = ovf_o;
    if (wr_ctrl && wdata[CTRL_OVF_BIT]) ovf_d = 1'b0;
    if (wrap) ovf_d = 1'b1;   // a new wrap wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_o       <= '0;
      low_stage_o <= '0;
      halt_o      <= 1'b1;
      ovf_o       <= 1'b0;
    end else begin
      adj_o       <= adj_d;
      low_stage_o <= low_d;
      halt_o      <= halt_d;
      ovf_o       <= ovf_d;
    end
  end
endmodule

// File: rtl/tc_readout.sv
module tc_readout #(
  parameter int NS_W = 40,
  parameter int FR_W = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [NS_W-1:0] live_ns,
  input  logic [FR_W-1:0] live_frac,
  input  logic [DW-1:0]   adj,
  input  logic            halt,
  input  logic            ovf,
  output logic [DW-1:0]   rdata
);
  import tc_pkg::*;

  logic [NS_W-1:0] snap_q;
  logic            snap_en;
  logic [DW-1:0]   rdata_d;
  logic [DW-1:0]   ctrl_word;

  always_comb begin
    snap_en   = rd_en && (addr == SEL_FRAC);
    ctrl_word = '0;
    ctrl_word[CTRL_HALT_BIT] = halt;
    ctrl_word[CTRL_OVF_BIT]  = ovf;
    case (addr)
      SEL_FRAC: rdata_d = DW'(live_frac);
      SEL_NSLO: rdata_d = snap_q[DW-1:0];
      SEL_NSHI: rdata_d = DW'(snap_q[NS_W-1:DW]);
      SEL_ADJ:  rdata_d = adj;
      SEL_CTRL: rdata_d = ctrl_word;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_en) begin
      snap_q <= live_ns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int NS_W    = 40,
  parameter int FR_W    = 32,
  parameter int DW      = 32,
  parameter int STEP_NS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NS_W-1:0] time_ns,
  output logic            ovf_flag
);
  import tc_pkg::*;

  localparam int HI_W = NS_W - DW;

  logic            rst_sync_n;
  logic            halt, ovf, wrap, load_hi;
  logic [DW-1:0]   adj, low_stage;
  logic [FR_W-1:0] frac;
  logic [NS_W-1:0] load_val;

  tc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tc_ctrl #(.DW(DW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .wrap        (wrap),
    .adj_o       (adj),
    .low_stage_o (low_stage),
    .halt_o      (halt),
    .ovf_o       (ovf)
  );

  assign load_hi  = bus_wr && (bus_addr == SEL_NSHI);
  assign load_val = {bus_wdata[HI_W-1:0], low_stage};

  tc_accum #(.NS_W(NS_W), .FR_W(FR_W), .STEP_NS(STEP_NS)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (!halt),
    .load    (load_hi),
    .load_ns (load_val),
    .adj_neg (adj[DW-1]),
    .adj_mag (adj[FR_W-2:0]),
    .ns_o    (time_ns),
    .frac_o  (frac),
    .wrap_o  (wrap)
  );

  tc_readout #(.NS_W(NS_W), .FR_W(FR_W), .DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .live_ns   (time_ns),
    .live_frac (frac),
    .adj       (adj),
    .halt      (halt),
    .ovf       (ovf),
    .rdata     (bus_rdata)
  );

  assign ovf_flag = ovf;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int NS_W = 40,
  parameter int FR_W = 32,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [2:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NS_W-1:0] time_ns,
  input logic [FR_W-1:0] frac,
  input logic            halt,
  input logic            ovf_flag
);
  localparam int HI_W = NS_W - DW;

  logic wr_hi, clr_ovf, rd_hi;
  assign wr_hi   = bus_wr && (bus_addr == 3'd2);
  assign rd_hi   = bus_rd && (bus_addr == 3'd2);
  assign clr_ovf = bus_wr && (bus_addr == 3'd4) && bus_wdata[0];

  // R2: halted time stays put unless loaded
  a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt && !wr_hi) |=> ($stable(time_ns) && $stable(frac)));

  // R3: one tick moves the ns count by 7, 8 or 9 (step within 8 +/- 0.5 ns)
  a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!halt && !wr_hi) |=> ((time_ns - $past(time_ns)) == NS_W'(7) ||
                           (time_ns - $past(time_ns)) == NS_W'(8) ||
                           (time_ns - $past(time_ns)) == NS_W'(9)));

  // R5: reserved bits of the high word read zero
  a_r5_high_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_hi |=> (bus_rdata[DW-1:HI_W] == '0));

  // R6: a high-word write loads the upper bits and clears the fraction
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_hi |=> (frac == '0 && time_ns[NS_W-1:DW] == $past(bus_wdata[HI_W-1:0])));

  // R7: the wrap flag only drops on a write-one clear
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
endmodule

bind ptp_time_counter tc_checker #(.NS_W(NS_W), .FR_W(FR_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .time_ns    (time_ns),
  .frac       (frac),
  .halt       (halt),
  .ovf_flag   (ovf_flag)
);

// File: tb/test_ptp_time_counter.sv
module test_ptp_time_counter;
  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [39:0] time_ns;
  logic        ovf_flag;

  int n_chk;
  int n_bad;
  bit done;

  localparam logic [31:0] HALT = 32'h8000_0000;

  ptp_time_counter i_ptp_time_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .time_ns   (time_ns),
    .ovf_flag  (ovf_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every bus task takes exactly one rising edge, entering and leaving at a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_time(input logic [39:0] t);
    bus_write(3'd1, t[31:0]);
    bus_write(3'd2, {24'hABCDEF, t[39:32]});
  endtask

  // runs exactly n ticks, n >= 1
  task automatic run_ticks(input int n);
    bus_write(3'd4, 32'h0);
    idle(n - 1);
    bus_write(3'd4, HALT);
  endtask

  task automatic read_time(output logic [71:0] v);
    logic [31:0] f, lo, hi;
    bus_read(3'd0, f);
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    v = {hi[7:0], lo, f};
  endtask

  function automatic logic [79:0] expect_time(input logic [39:0] t, input logic [31:0] adj,
                                              input int n);
    logic [79:0] step;
    step = {40'd0, 8'd8, 32'd0};
    if (adj[31]) step = step - {49'd0, adj[30:0]};
    else         step = step + {49'd0, adj[30:0]};
    return {8'd0, t, 32'd0} + step * 80'(n);
  endfunction

  initial begin
    done = 1'b0;
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [71:0] v;
    logic [79:0] e;
    logic [39:0] t;
    logic [31:0] adj;
    int n;
    void'($urandom(32'd12345));
    n_chk = 0; n_bad = 0;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    read_time(v);
    check("R1 time", 80'(v), 80'd0);
    bus_read(3'd3, d); check("R1 adj", 80'(d), 80'd0);
    bus_read(3'd4, d); check("R1 ctrl", 80'(d), 80'(HALT));
    check("R1 ovf_flag", 80'(ovf_flag), 80'd0);

    // R2 halted: nothing moves
    idle(10);
    check("R2 halted time_ns", 80'(time_ns), 80'd0);

    // R6 staged low does not touch the time; high write loads; R5 high reserved
    bus_write(3'd1, 32'h1234_5678);
    idle(1);
    check("R6 low write alone", 80'(time_ns), 80'd0);
    bus_write(3'd2, 32'hFFFF_FF5A);
    check("R6 loaded", 80'(time_ns), 80'h5A_1234_5678);
    check("R10 live output", 80'(time_ns), 80'h5A_1234_5678);
    bus_read(3'd0, d);
    bus_read(3'd2, d);
    check("R5 high word", 80'(d), 80'h5A);

    // R8 fraction writes ignored
    bus_write(3'd0, 32'hDEAD_BEEF);
    read_time(v);
    check("R8 frac write ignored", 80'(v), {8'd0, 40'h5A_1234_5678, 32'd0});

    // R9 adjust readback, R3 basic run with zero adjust
    bus_write(3'd3, 32'h8000_0100);
    bus_read(3'd3, d);
    check("R9 adj readback", 80'(d), 80'h8000_0100);
    bus_write(3'd3, 32'h0);
    load_time(40'd1000);
    run_ticks(5);
    read_time(v);
    check("R3 five ticks", 80'(v), expect_time(40'd1000, 32'd0, 5));

    // R4 snapshot taken while running is kept
    load_time(40'd5000);
    bus_write(3'd4, 32'h0);        // start
    bus_read(3'd0, d);             // capture before first tick
    check("R4 frac at capture", 80'(d), 80'd0);
    idle(6);
    bus_write(3'd4, HALT);
    bus_read(3'd1, d);
    check("R4 low from snapshot", 80'(d), 80'd5000);
    bus_read(3'd2, d);
    check("R4 high from snapshot", 80'(d), 80'd0);
    read_time(v);
    check("R4 fresh capture", 80'(v), expect_time(40'd5000, 32'd0, 8));

    // R7 wrap of the count
    load_time(40'hFF_FFFF_FFF6);
    run_ticks(3);
    check("R7 flag set", 80'(ovf_flag), 80'd1);
    check("R7 wrapped time", 80'(time_ns), 80'd14);
    bus_write(3'd4, HALT);
    bus_read(3'd4, d);
    check("R7 write zero keeps flag", 80'(d), 80'h8000_0001);
    bus_write(3'd4, HALT | 32'h1);
    bus_read(3'd4, d);
    check("R7 write one clears flag", 80'(d), 80'(HALT));

    // R3 R7 randomised trials with adjust of both signs
    for (int i = 0; i < 24; i++) begin
      t   = {8'($urandom), 32'($urandom)};
      if (i % 4 == 0) t[39:8] = 32'hFFFF_FFFF;
      adj = $urandom;
      n   = 1 + int'($urandom % 40);
      bus_write(3'd4, HALT | 32'h1);
      bus_write(3'd3, adj);
      load_time(t);
      run_ticks(n);
      e = expect_time(t, adj, n);
      read_time(v);
      check("R3 random time", 80'(v), {8'd0, e[71:0]});
      bus_read(3'd4, d);
      check("R7 random flag", 80'(d), {48'd0, HALT | {31'd0, (e[79:72] != 8'd0)}});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule